// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block keeps the wall-clock time and the calendar date as a chain of eight packed BCD byte counters. The counters are hundredths of a second, seconds, minutes, hours, weekday, date, month and a two-digit year. A one-cycle `tick` pulse arrives once every hundredth of a second. It advances the finest counter, and each counter that wraps carries into the next coarser one. At midnight the hour carry drives two day counters at once: a weekday counter that just cycles, and a date counter whose last value depends on the month and on the year.

All eight fields are driven in parallel on output ports, so a register front end can read them without any extra handshake. A `load` strobe writes all eight fields at once in a single cycle. This is how the time is preset, and a bench uses it to jump straight to the boundaries of interest. Reset is synchronous.

Top module: `cal_clock_chain`

## Requirements
- R1: Every field is packed BCD: bits [7:4] hold the tens digit and bits [3:0] the units digit, and neither digit ever exceeds 9.
- R2: The hundredths field advances by one on each cycle with `tick` high, from 00 up to 99 and then back to 00. With neither `tick` nor a carry arriving, a field keeps its value.
- R3: Seconds and minutes each count 00 to 59. On the step after 59 the field becomes 00 and the next coarser field advances in the same cycle.
- R4: Hours count 00 to 23 in 24-hour form. The step after 23 gives 00 and advances both the weekday and the date in the same cycle.
- R5: The weekday counts 0 to 6 and returns to 0. It changes only on the midnight carry, and its value never affects the date, month or year.
- R6: The date starts at 01. After the last day of the current month it returns to 01 and advances the month. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R7: February (month 02) ends on day 29 when the year value is a multiple of 4, including 00, and on day 28 otherwise.
- R8: The month counts 01 to 12 and never holds 00. After month 12 it returns to 01 and advances the year.
- R9: The year holds two decimal digits and goes from 99 to 00.
- R10: When `load` is high, every field takes its load value on the next edge, even if `tick` is also high in that cycle.
- R11: A cycle with `rst` high sets the fields to 00.00 hundredths, 00 seconds, 00 minutes, 00 hours, weekday 0, date 01, month 01 and year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Pulse once per hundredth of a second |
| load | input | 1 | Preset strobe for all fields |
| ld_hsec | input | 8 | Load value, hundredths (BCD) |
| ld_sec | input | 8 | Load value, seconds (BCD) |
| ld_min | input | 8 | Load value, minutes (BCD) |
| ld_hour | input | 8 | Load value, hours (BCD) |
| ld_wday | input | 8 | Load value, weekday (BCD, 0-6) |
| ld_mday | input | 8 | Load value, date (BCD) |
| ld_mon | input | 8 | Load value, month (BCD) |
| ld_year | input | 8 | Load value, year (BCD) |
| hsec | output | 8 | Hundredths of a second |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hour | output | 8 | Hours |
| wday | output | 8 | Weekday |
| mday | output | 8 | Date |
| mon | output | 8 | Month |
| year | output | 8 | Year |

## Verification
On every cycle the assertions check the per-stage rules: digits stay valid, a field holds when nothing enables it, a field that wraps lands on its first value, a load wins over counting, and the hour, weekday, date and month stay inside their ranges. The checks cannot tell whether a carry goes to the correct neighbour, or whether the date limit for a given month and year is right. Only the bench scenarios show these, by comparing every cycle against an independent model. The model is walked across month ends, February in leap and common years, the turn of the year and a long stretch of plain counting.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef logic [7:0] bcd8_t;

  localparam int unsigned NUM_FIELDS = 8;

  // stage indices
  localparam int unsigned F_HSEC = 0;
  localparam int unsigned F_SEC  = 1;
  localparam int unsigned F_MIN  = 2;
  localparam int unsigned F_HOUR = 3;
  localparam int unsigned F_WDAY = 4;
  localparam int unsigned F_MDAY = 5;
  localparam int unsigned F_MON  = 6;
  localparam int unsigned F_YEAR = 7;

  // next packed-BCD value, units digit rolling into tens
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_ok(input bcd8_t v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  // multiple of four in BCD: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic bcd_leap(input bcd8_t y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic bcd8_t bcd_month_end(input bcd8_t m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_bcd_stage.sv
module cal_bcd_stage
  import cal_pkg::*;
#(
  parameter bcd8_t FIRST = 8'h00
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ld,
  input  bcd8_t ld_val,
  input  logic  en,
  input  bcd8_t last,
  output bcd8_t q,
  output logic  carry
);

  logic at_last;

  assign at_last = (q >= last);
  assign carry   = en && at_last;

  always_ff @(posedge clk) begin
    if (rst)      q <= FIRST;
    else if (ld)  q <= ld_val;
    else if (en)  q <= at_last ? FIRST : bcd_inc(q);
  end

  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(ld_val)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(q));

  a_r3_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
    (carry && !ld) |=> (q == FIRST));

  a_r1_bcd_digits: assert property (@(posedge clk) disable iff (rst)
    bcd_ok(q));

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  bcd8_t mon,
  input  bcd8_t year,
  output bcd8_t last_day,
  output logic  leap
);

  assign leap     = bcd_leap(year);
  assign last_day = bcd_month_end(mon, leap);

endmodule

// File: rtl/cal_clock_chain.sv
module cal_clock_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ld_hsec,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [7:0] hsec,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] wday,
  output logic [7:0] mday,
  output logic [7:0] mon,
  output logic [7:0] year
);

  // per-stage wiring tables; carry source -1 means the tick input
  localparam int    CARRY_SRC [NUM_FIELDS] = '{-1, 0, 1, 2, 3, 3, 5, 6};
  localparam bcd8_t FIRST_V   [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
  localparam bcd8_t LAST_V    [NUM_FIELDS] =
    '{8'h99, 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99};

  bcd8_t            q      [NUM_FIELDS];
  bcd8_t            ld_bus [NUM_FIELDS];
  bcd8_t            last   [NUM_FIELDS];
  logic  [NUM_FIELDS-1:0] en;
  logic  [NUM_FIELDS-1:0] carry;
  bcd8_t            month_end;
  logic             leap_year;

  // named events for the checks below
  logic midnight;
  logic month_roll;
  assign midnight   = carry[F_HOUR];
  assign month_roll = carry[F_MDAY];

  assign ld_bus[F_HSEC] = ld_hsec;
  assign ld_bus[F_SEC]  = ld_sec;
  assign ld_bus[F_MIN]  = ld_min;
  assign ld_bus[F_HOUR] = ld_hour;
  assign ld_bus[F_WDAY] = ld_wday;
  assign ld_bus[F_MDAY] = ld_mday;
  assign ld_bus[F_MON]  = ld_mon;
  assign ld_bus[F_YEAR] = ld_year;

  cal_month_len u_mlen (
    .mon      (q[F_MON]),
    .year     (q[F_YEAR]),
    .last_day (month_end),
    .leap     (leap_year)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_stage
    if (CARRY_SRC[i] < 0) begin : g_src_tick
      assign en[i] = tick;
    end else begin : g_src_carry
      assign en[i] = carry[CARRY_SRC[i]];
    end

    if (i == F_MDAY) begin : g_dyn_last
      assign last[i] = month_end;
    end else begin : g_fix_last
      assign last[i] = LAST_V[i];
    end

    cal_bcd_stage #(.FIRST(FIRST_V[i])) u_stage (
      .clk    (clk),
      .rst    (rst),
      .ld     (load),
      .ld_val (ld_bus[i]),
      .en     (en[i]),
      .last   (last[i]),
      .q      (q[i]),
      .carry  (carry[i])
    );
  end

  assign hsec = q[F_HSEC];
  assign sec  = q[F_SEC];
  assign min  = q[F_MIN];
  assign hour = q[F_HOUR];
  assign wday = q[F_WDAY];
  assign mday = q[F_MDAY];
  assign mon  = q[F_MON];
  assign year = q[F_YEAR];

  a_r4_hour_range: assert property (@(posedge clk) disable iff (rst)
    hour <= 8'h23);

  a_r5_wday_range: assert property (@(posedge clk) disable iff (rst)
    wday <= 8'h06);

  a_r8_month_range: assert property (@(posedge clk) disable iff (rst)
    (mon >= 8'h01) && (mon <= 8'h12));

  a_r6_date_range: assert property (@(posedge clk) disable iff (rst)
    (mday >= 8'h01) && (mday <= 8'h31));

  a_r4_midnight_zero: assert property (@(posedge clk) disable iff (rst)
    (midnight && !load) |=> (hour == 8'h00) && (min == 8'h00) && (sec == 8'h00));

  a_r6_month_roll_date: assert property (@(posedge clk) disable iff (rst)
    (month_roll && !load) |=> (mday == 8'h01));

endmodule

// File: tb/test_cal_clock_chain.sv
`timescale 1ns/100ps
module test_cal_clock_chain;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       load = 1'b0;
  logic [7:0] l_hs = '0, l_s = '0, l_mi = '0, l_h = '0;
  logic [7:0] l_wd = '0, l_md = '0, l_mo = '0, l_yr = '0;
  logic [7:0] hsec, sec, min, hour, wday, mday, mon, year;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // scoreboard
  logic [63:0] exp_q [$];
  string       tag_q [$];

  // bench model, plain integers
  int m_hs, m_s, m_mi, m_h, m_wd, m_md, m_mo, m_yr;

  always #2.5 clk = ~clk;

  cal_clock_chain i_cal_clock_chain (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .ld_hsec(l_hs), .ld_sec(l_s), .ld_min(l_mi), .ld_hour(l_h),
    .ld_wday(l_wd), .ld_mday(l_md), .ld_mon(l_mo), .ld_year(l_yr),
    .hsec(hsec), .sec(sec), .min(min), .hour(hour),
    .wday(wday), .mday(mday), .mon(mon), .year(year)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_of(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] model_word();
    return {to_bcd(m_hs), to_bcd(m_s), to_bcd(m_mi), to_bcd(m_h),
            to_bcd(m_wd), to_bcd(m_md), to_bcd(m_mo), to_bcd(m_yr)};
  endfunction

  task automatic model_advance();
    m_hs++;
    if (m_hs == 100) begin
      m_hs = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_h++;
          if (m_h == 24) begin
            m_h = 0;
            m_wd = (m_wd + 1) % 7;
            if (m_md >= days_of(m_mo, m_yr)) begin
              m_md = 1; m_mo++;
              if (m_mo == 13) begin
                m_mo = 1;
                m_yr = (m_yr + 1) % 100;
              end
            end else m_md++;
          end
        end
      end
    end
  endtask

  // driver: one cycle of stimulus, one expected item
  task automatic drive(input bit r, input bit t, input bit l, input string tag);
    @(negedge clk);
    rst = r; tick = t; load = l;
    if (r) begin
      m_hs = 0; m_s = 0; m_mi = 0; m_h = 0; m_wd = 0; m_md = 1; m_mo = 1; m_yr = 0;
    end else if (l) begin
      m_hs = int'(l_hs[7:4]) * 10 + int'(l_hs[3:0]);
      m_s  = int'(l_s[7:4])  * 10 + int'(l_s[3:0]);
      m_mi = int'(l_mi[7:4]) * 10 + int'(l_mi[3:0]);
      m_h  = int'(l_h[7:4])  * 10 + int'(l_h[3:0]);
      m_wd = int'(l_wd[7:4]) * 10 + int'(l_wd[3:0]);
      m_md = int'(l_md[7:4]) * 10 + int'(l_md[3:0]);
      m_mo = int'(l_mo[7:4]) * 10 + int'(l_mo[3:0]);
      m_yr = int'(l_yr[7:4]) * 10 + int'(l_yr[3:0]);
    end else if (t) begin
      model_advance();
    end
    exp_q.push_back(model_word());
    tag_q.push_back(tag);
  endtask

  task automatic preset(input int hs, input int s, input int mi, input int h,
                        input int wd, input int md, input int mo, input int yr,
                        input bit with_tick, input string tag);
    @(negedge clk);
    l_hs = to_bcd(hs); l_s = to_bcd(s); l_mi = to_bcd(mi); l_h = to_bcd(h);
    l_wd = to_bcd(wd); l_md = to_bcd(md); l_mo = to_bcd(mo); l_yr = to_bcd(yr);
    drive(0, with_tick, 1, tag);
  endtask

  // monitor: compare one item per edge, just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      logic [63:0] a;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      a = {hsec, sec, min, hour, wday, mday, mon, year};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h (hs s mi h wd md mo yr)", tg, a, e);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=still running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset values
    drive(1, 0, 0, "R11 reset");
    drive(1, 1, 0, "R11 reset with tick");

    // R2: counting and holding
    for (int i = 0; i < 5; i++) drive(0, 1, 0, "R2 hundredths count");
    drive(0, 0, 0, "R2 hold without tick");
    drive(0, 0, 0, "R2 hold without tick");

    // R2, R3: 99 to 00 into seconds, 59 seconds into minutes
    preset(98, 58, 10, 5, 2, 10, 6, 30, 0, "R10 preset");
    for (int i = 0; i < 105; i++) drive(0, 1, 0, "R2 R3 seconds carry");
    preset(97, 59, 59, 12, 2, 10, 6, 30, 0, "R10 preset");
    for (int i = 0; i < 5; i++) drive(0, 1, 0, "R3 minute and hour carry");

    // R4, R5, R6, R8, R9: everything rolls at once
    preset(99, 59, 59, 23, 6, 31, 12, 99, 0, "R10 preset");
    drive(0, 1, 0, "R4 R5 R6 R8 R9 full rollover");
    drive(0, 1, 0, "R1 after rollover");

    // R5: weekday independent of date
    preset(99, 59, 59, 23, 3, 15, 7, 12, 0, "R10 preset");
    drive(0, 1, 0, "R5 weekday with mid-month date");

    // R6: 30 and 31 day months
    preset(99, 59, 59, 23, 0, 30, 4, 21, 0, "R10 preset");
    drive(0, 1, 0, "R6 April end");
    preset(99, 59, 59, 23, 0, 30, 5, 21, 0, "R10 preset");
    drive(0, 1, 0, "R6 May 30 continues");
    preset(99, 59, 59, 23, 0, 30, 11, 21, 0, "R10 preset");
    drive(0, 1, 0, "R6 November end");
    preset(99, 59, 59, 23, 0, 31, 8, 21, 0, "R10 preset");
    drive(0, 1, 0, "R6 August end");

    // R7: February
    preset(99, 59, 59, 23, 1, 28, 2, 23, 0, "R10 preset");
    drive(0, 1, 0, "R7 February common year");
    preset(99, 59, 59, 23, 1, 28, 2, 24, 0, "R10 preset");
    drive(0, 1, 0, "R7 February leap year to 29");
    preset(99, 59, 59, 23, 1, 29, 2, 24, 0, "R10 preset");
    drive(0, 1, 0, "R7 February 29 end");
    preset(99, 59, 59, 23, 1, 28, 2, 0, 0, "R10 preset");
    drive(0, 1, 0, "R7 year 00 is leap");
    preset(99, 59, 59, 23, 1, 28, 2, 70, 0, "R10 preset");
    drive(0, 1, 0, "R7 year 70 not leap");

    // R10: load wins over tick
    preset(42, 17, 33, 8, 4, 19, 9, 55, 1, "R10 load with tick");
    drive(0, 0, 0, "R10 hold after load");

    // R1, R2, R3: long run across a minute
    preset(0, 58, 59, 23, 6, 31, 12, 99, 0, "R10 preset");
    for (int i = 0; i < 7000; i++) drive(0, 1, 0, "R1 R3 long run");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule